// File: doc/BRIEF.md
# Continuous Masked Serial Pattern Matcher

This block samples a one-bit serial line at a shift rate divided down from its reference clock and keeps the last sixteen samples in a sliding window. On every shift it compares the whole window against a programmable compare word. A companion mask word marks some positions as "don't care". The result drives a match flag that downstream logic can use as a trigger. It needs no software once it is set up. A typical use is a glitch-free edge detector: eight steady samples of one level followed by eight steady samples of the other.

The shift rate comes from an internal divider. The divider toggles an internal shift clock, and a sample is taken on each falling edge of that clock. A sequence counter counts both edges of the shift clock. When it reaches its programmed limit, shifting stops and the window and flag freeze. A rising edge on the restart input clears the counter and the divider phase. Pulsing restart periodically keeps the matcher running indefinitely.

Top module: `serial_pattern_matcher`

## Requirements
- R1: Synchronous reset (rst high) clears the window to all zeros, clears the divider and sequence counter, and drives match_o low; match_o stays low until the first shift, even when the pattern would accept an all-zero window.
- R2: A shift happens exactly 2*(div_cmp+1) reference clocks after reset release, after a restart edge, or after the previous shift; match_o does not change before that edge.
- R3: Each shift inserts ser_in at window bit 15 (the newest position) and moves every other bit one place toward bit 0.
- R4: pat_word[31:16] is the compare value and pat_word[15:0] the mask; a mask bit of 1 ignores that window position, and a match requires every unmasked window bit to equal its compare bit.
- R5: match_o is recomputed on the same clock edge as each shift from the new window, holds its value between shifts, and falls on the first shift whose window mismatches.
- R6: With pat_word = 0xFF000000, match_o rises only after eight 0 samples followed by eight 1 samples; any glitch inside that run prevents the match.
- R7: With pat_word = 0x00FF0000, match_o rises only after eight 1 samples followed by eight 0 samples.
- R8: The sequence counter advances on both edges of the shift clock; with shift_cmp = 2*N-1, exactly N shifts occur after reset or restart, and then the window and match_o stay frozen.
- R9: A 0-to-1 transition on cnt_restart clears the sequence counter, the stop state and the divider phase; a level held high has no further effect, and the restart edge takes priority over a shift in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data sampled on each shift |
| pat_word | input | 32 | Compare value in [31:16], ignore mask in [15:0] |
| div_cmp | input | 16 | Divider compare; half shift period minus one, in reference clocks |
| shift_cmp | input | 16 | Sequence limit in shift-clock edges, 2*N-1 for N shifts |
| cnt_restart | input | 1 | Rising edge restarts the sequence counter and divider |
| match_o | output | 1 | High while the latest window matches the pattern |

## Verification
The bench uses the default widths: a 16-sample window, a 16-bit divider and a 16-bit sequence counter. It changes div_cmp at run time between 3 (eight clocks per shift) and 1 (four clocks per shift). This exercises the shift-spacing rule at two rates within a short run. A sequence limit of 9 (five shifts) makes timeout, freezing, held-level restart and periodic restart reachable in a few dozen shifts. A limit of 59999 keeps the counter out of the way for the pattern tests.

// File: rtl/smatch_pkg.sv
package smatch_pkg;

  typedef enum logic {
    SCLK_LO = 1'b0,
    SCLK_HI = 1'b1
  } sclk_e;

  // Reference clocks between two shifts for a given divider compare.
  function automatic int unsigned sm_period(input int unsigned dcmp);
    return 2 * (dcmp + 1);
  endfunction

  // Sequence-counter compare that allows exactly n shifts.
  function automatic int unsigned sm_limit(input int unsigned n);
    return 2 * n - 1;
  endfunction

endpackage

// File: rtl/smatch_clkdiv.sv
module smatch_clkdiv
  import smatch_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_cmp,
  output logic             tog,
  output logic             fall
);

  logic [DIV_W-1:0] cnt_q;
  sclk_e            ph_q;

  // Shift clock toggles when the half-period count is reached.
  assign tog  = !rst && !restart && (cnt_q >= div_cmp);
  assign fall = tog && (ph_q == SCLK_HI);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
      ph_q  <= SCLK_LO;
    end else if (tog) begin
      cnt_q <= '0;
      ph_q  <= (ph_q == SCLK_HI) ? SCLK_LO : SCLK_HI;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

endmodule

// File: rtl/smatch_seqctr.sv
module smatch_seqctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             tog,
  input  logic             fall,
  input  logic [CNT_W-1:0] shift_cmp,
  output logic             shift_en,
  output logic             stopped,
  output logic [CNT_W-1:0] edge_cnt
);

  logic [CNT_W-1:0] cnt_q;
  logic             stop_q;

  // The edge that reaches the limit still performs its shift.
  assign shift_en = fall && !stop_q;
  assign stopped  = stop_q;
  assign edge_cnt = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q  <= '0;
      stop_q <= 1'b0;
    end else if (tog && !stop_q) begin
      if (cnt_q == shift_cmp) begin
        stop_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/smatch_window.sv
module smatch_window #(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             ser_in,
  input  logic [WIN_W-1:0] cmp,
  input  logic [WIN_W-1:0] msk,
  output logic [WIN_W-1:0] win,
  output logic             match
);

  logic [WIN_W-1:0] win_q;
  logic [WIN_W-1:0] win_nx;
  logic [WIN_W-1:0] bit_ok;
  logic             match_q;

  // Newest sample enters at the top of the window.
  assign win_nx = {ser_in, win_q[WIN_W-1:1]};

  for (genvar i = 0; i < WIN_W; i++) begin : g_cmp
    assign bit_ok[i] = msk[i] || (win_nx[i] == cmp[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q   <= '0;
      match_q <= 1'b0;
    end else if (shift_en) begin
      win_q   <= win_nx;
      match_q <= &bit_ok;
    end
  end

  assign win   = win_q;
  assign match = match_q;

endmodule

// File: rtl/serial_pattern_matcher.sv
module serial_pattern_matcher
  import smatch_pkg::*;
#(
  parameter int WIN_W = 16,
  parameter int DIV_W = 16,
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ser_in,
  input  logic [2*WIN_W-1:0] pat_word,
  input  logic [DIV_W-1:0]   div_cmp,
  input  logic [CNT_W-1:0]   shift_cmp,
  input  logic               cnt_restart,
  output logic               match_o
);

  localparam int PAT_W = 2 * WIN_W;

  logic             restart_q;
  logic             restart_rise;
  logic             sclk_tog;
  logic             sclk_fall;
  logic             shift_evt;
  logic             seq_stopped;
  logic [CNT_W-1:0] edge_cnt;
  logic [WIN_W-1:0] win_q;

  always_ff @(posedge clk) begin
    if (rst) restart_q <= 1'b0;
    else     restart_q <= cnt_restart;
  end

  assign restart_rise = !rst && cnt_restart && !restart_q;

  smatch_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .restart (restart_rise),
    .div_cmp (div_cmp),
    .tog     (sclk_tog),
    .fall    (sclk_fall)
  );

  smatch_seqctr #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart_rise),
    .tog       (sclk_tog),
    .fall      (sclk_fall),
    .shift_cmp (shift_cmp),
    .shift_en  (shift_evt),
    .stopped   (seq_stopped),
    .edge_cnt  (edge_cnt)
  );

  smatch_window #(.WIN_W(WIN_W)) u_win (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_evt),
    .ser_in   (ser_in),
    .cmp      (pat_word[PAT_W-1:WIN_W]),
    .msk      (pat_word[WIN_W-1:0]),
    .win      (win_q),
    .match    (match_o)
  );

endmodule

// File: rtl/smatch_checker.sv
module smatch_checker
  import smatch_pkg::*;
#(
  parameter int WIN_W = 16,
  parameter int DIV_W = 16,
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               ser_in,
  input logic [2*WIN_W-1:0] pat_word,
  input logic [DIV_W-1:0]   div_cmp,
  input logic               restart_rise,
  input logic               shift_evt,
  input logic               seq_stopped,
  input logic [CNT_W-1:0]   edge_cnt,
  input logic [WIN_W-1:0]   win_q,
  input logic               match_o
);

  logic [31:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst || restart_rise || shift_evt) gap_q <= '0;
    else                                  gap_q <= gap_q + 32'd1;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!match_o && win_q == '0 && edge_cnt == '0));

  p_shift_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    shift_evt |-> (gap_q + 32'd1 == sm_period(32'(div_cmp))));

  p_newest_top_r3: assert property (@(posedge clk) disable iff (rst)
    shift_evt |=> (win_q[WIN_W-1] == $past(ser_in) &&
                   win_q[WIN_W-2:0] == $past(win_q[WIN_W-1:1])));

  p_match_value_r4: assert property (@(posedge clk) disable iff (rst)
    shift_evt |=> (match_o == (((win_q ^ $past(pat_word[2*WIN_W-1:WIN_W]))
                                & ~$past(pat_word[WIN_W-1:0])) == '0)));

  p_hold_between_r5: assert property (@(posedge clk) disable iff (rst)
    !shift_evt |=> $stable(match_o));

  p_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (seq_stopped && !restart_rise) |=> $stable(win_q));

  p_restart_clear_r9: assert property (@(posedge clk) disable iff (rst)
    restart_rise |=> (edge_cnt == '0 && !seq_stopped));

endmodule

bind serial_pattern_matcher smatch_checker #(
  .WIN_W(WIN_W),
  .DIV_W(DIV_W),
  .CNT_W(CNT_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ser_in       (ser_in),
  .pat_word     (pat_word),
  .div_cmp      (div_cmp),
  .restart_rise (restart_rise),
  .shift_evt    (shift_evt),
  .seq_stopped  (seq_stopped),
  .edge_cnt     (edge_cnt),
  .win_q        (win_q),
  .match_o      (match_o)
);

// File: tb/sim_serial_pattern_matcher.sv
module sim_serial_pattern_matcher;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_in = 1'b0;
  logic [31:0] pat_word = '0;
  logic [15:0] div_cmp = 16'd3;
  logic [15:0] shift_cmp = 16'hFFFF;
  logic        cnt_restart = 1'b0;
  logic        match_o;

  always #10 clk = ~clk;

  serial_pattern_matcher u0 (
    .clk         (clk),
    .rst         (rst),
    .ser_in      (ser_in),
    .pat_word    (pat_word),
    .div_cmp     (div_cmp),
    .shift_cmp   (shift_cmp),
    .cnt_restart (cnt_restart),
    .match_o     (match_o)
  );

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  item_t     sb_q[$];
  int        checks = 0;
  int        errors = 0;
  int        sp = 8;
  int        lim = 30000;
  int        since = 0;
  logic      exp_prev = 1'b0;
  bit [15:0] mwin = '0;
  bit [15:0] mcmp = '0;
  bit [15:0] mmsk = '0;
  bit        done = 1'b0;

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: match_o=%0b expected %0b", tag, act, exp);
    end
  endtask

  function automatic bit model_hit();
    bit h = 1'b1;
    for (int i = 0; i < 16; i++)
      if (!mmsk[i] && (mwin[i] != mcmp[i])) h = 1'b0;
    return h;
  endfunction

  task automatic set_pat(input bit [15:0] c, input bit [15:0] m);
    pat_word = {c, m};
    mcmp = c;
    mmsk = m;
  endtask

  task automatic do_reset(input int d, input int nshift);
    @(negedge clk);
    rst = 1'b1;
    cnt_restart = 1'b0;
    div_cmp = 16'(d);
    shift_cmp = 16'(2 * nshift - 1);
    sp = (d + 1) * 2;
    lim = nshift;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mwin = '0;
    since = 0;
    exp_prev = 1'b0;
    chk(match_o, 1'b0, "R1 match low after reset");
  endtask

  // Called at a negedge; returns at the negedge after the shift edge.
  task automatic send_bit(input bit b, input string tag);
    ser_in = b;
    repeat (sp - 1) @(posedge clk);
    @(negedge clk);
    chk(match_o, exp_prev, "R2 no change before shift period");
    @(posedge clk);
    if (since < lim) begin
      mwin = {b, mwin[15:1]};
      since++;
      exp_prev = model_hit();
    end
    sb_q.push_back('{exp_prev, tag});
    @(negedge clk);
  endtask

  task automatic restart_pulse(input bit hold);
    cnt_restart = 1'b1;
    @(posedge clk);
    since = 0;
    @(negedge clk);
    if (!hold) cnt_restart = 1'b0;
  endtask

  // Monitor: compare each expected item at the negedge after its shift.
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        chk(match_o, it.exp, it.tag);
      end
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [15:0] lf;

    // R1: all-zero pattern; first shifted 0 gives a match only if reset zeroed the window
    do_reset(3, 30000);
    set_pat(16'h0000, 16'h0000);
    send_bit(1'b0, "R1 window cleared to zeros");

    // R6: rising edge, then R5 drop
    set_pat(16'hFF00, 16'h0000);
    for (int i = 0; i < 8; i++) send_bit(1'b0, "R6 low run");
    for (int i = 0; i < 8; i++) send_bit(1'b1, "R6 rising edge");
    send_bit(1'b1, "R5 drop on mismatch");
    for (int i = 0; i < 8; i++) send_bit(1'b0, "R6 low run");
    for (int i = 0; i < 3; i++) send_bit(1'b1, "R6 glitch rejected");
    send_bit(1'b0, "R6 glitch rejected");
    for (int i = 0; i < 4; i++) send_bit(1'b1, "R6 glitch rejected");

    // R7: falling edge
    set_pat(16'h00FF, 16'h0000);
    for (int i = 0; i < 8; i++) send_bit(1'b1, "R7 high run");
    for (int i = 0; i < 8; i++) send_bit(1'b0, "R7 falling edge");
    send_bit(1'b0, "R5 drop on mismatch");

    // R4: masked compare, random stream then an exact fill
    set_pat(16'hA5C3, 16'h0F0F);
    lf = 16'hACE1;
    for (int i = 0; i < 40; i++) begin
      send_bit(lf[0], "R4 masked compare");
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    end
    for (int i = 0; i < 16; i++) send_bit(mcmp[i], "R4 masked compare fill");
    send_bit(1'b0, "R4 masked compare");

    // R3: newest at bit 15, oldest at bit 0
    set_pat(16'h8000, 16'h7FFF);
    send_bit(1'b1, "R3 newest at top");
    send_bit(1'b0, "R3 newest at top");
    send_bit(1'b1, "R3 newest at top");
    set_pat(16'h0001, 16'hFFFE);
    send_bit(1'b1, "R3 oldest at bottom");
    for (int i = 0; i < 15; i++) send_bit(1'b0, "R3 oldest at bottom");
    send_bit(1'b0, "R3 oldest at bottom");

    // R2: faster divider
    do_reset(1, 30000);
    set_pat(16'h8000, 16'h7FFF);
    send_bit(1'b1, "R2 period four clocks");
    send_bit(1'b0, "R2 period four clocks");
    send_bit(1'b1, "R2 period four clocks");
    send_bit(1'b1, "R2 period four clocks");
    send_bit(1'b0, "R2 period four clocks");

    // R8: five shifts then frozen
    do_reset(3, 5);
    set_pat(16'h8000, 16'h7FFF);
    send_bit(1'b0, "R8 within limit");
    send_bit(1'b1, "R8 within limit");
    send_bit(1'b0, "R8 within limit");
    send_bit(1'b1, "R8 within limit");
    send_bit(1'b1, "R8 last shift");
    for (int i = 0; i < 3; i++) send_bit(1'b0, "R8 frozen after limit");

    // R9: restart pulse resumes shifting
    restart_pulse(1'b0);
    send_bit(1'b0, "R9 restart resumes");
    for (int i = 0; i < 4; i++) send_bit(1'b1, "R9 restart resumes");
    send_bit(1'b0, "R8 frozen after limit");

    // R9: level held high gives only one restart
    restart_pulse(1'b1);
    send_bit(1'b0, "R9 held level");
    send_bit(1'b1, "R9 held level");
    send_bit(1'b0, "R9 held level");
    send_bit(1'b1, "R9 held level");
    send_bit(1'b1, "R9 held level");
    send_bit(1'b0, "R9 held level no second restart");
    cnt_restart = 1'b0;
    send_bit(1'b0, "R9 release has no effect");

    // R8: periodic restart keeps the matcher running
    for (int k = 0; k < 5; k++) begin
      restart_pulse(1'b0);
      for (int i = 0; i < 4; i++) send_bit(((i + k) % 2) == 0, "R8 periodic restart avoids timeout");
    end

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule